// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block keeps a small byte queue of upcoming instruction bytes between a 16-bit bus fetch engine and an execution consumer. While the queue has room it runs word reads on a simple memory port, at the physical address formed from a 16-bit segment and a 16-bit offset, and appends the returned bytes in address order. The consumer takes bytes through a valid/ready pop port at the same time as fetching continues.

A redirect input, used for jumps, loads a new segment and offset, empties the queue, and marks any read still on the bus so that its data is thrown away. Fetching then resumes at the new address. After reset the queue is empty, the offset is zero and the segment is all ones, so the first read goes to FFFF0h. Each bus read takes a fixed sequence of four clock phases, and the third phase repeats while the memory holds its ready input low.

Top module: `ifq_prefetch`

## Requirements
- R1: While reset is held, and right after it, `deq_valid` is 0. The first clock edge after reset is released starts a read, so `mem_req` is 1 in the next cycle with `mem_addr` = FFFF0h.
- R2: The read address is segment×16 + offset, taken modulo 2^20. It is captured when the read starts and holds steady until the read ends.
- R3: A read lasts at least four cycles. `mem_req` is high only in the first cycle. `mem_rdata` is sampled at the end of the third cycle, and that cycle repeats while `mem_ready` is 0. A read with `mem_ready` held at 1 starts the next one four cycles later.
- R4: A new read starts only when at least 2 of the 6 byte slots are free, as counted in the cycle the decision is made. With no pops and `mem_ready` held at 1, exactly 3 reads happen after reset.
- R5: When the read address is even, both bytes are queued, the low byte (bits 7:0 of `mem_rdata`) first, and the offset grows by 2.
- R6: When the read address is odd, only the high byte (bits 15:8 of `mem_rdata`, the byte at that odd address) is queued, and the offset grows by 1.
- R7: `deq_valid` is 1 exactly when the queue holds a byte, and `deq_byte` is then the oldest byte. A byte leaves on a clock edge where both `deq_valid` and `deq_ready` are 1. A `deq_ready` with an empty queue has no effect.
- R8: The queue never holds more than 6 bytes. A pop and an append may happen on the same edge, so reads continue while the consumer drains.
- R9: A `redir_valid` cycle loads `redir_seg`/`redir_off`, empties the queue (`deq_valid` is 0 in the next cycle), ignores a pop in the same cycle, and starts no read on that edge.
- R10: Data from a read that was on the bus when a redirect arrived, including one that ends on the redirect edge, is never queued, and it does not advance the offset.
- R11: The offset wraps within 16 bits (FFFFh + 1 = 0000h), and a physical address above FFFFFh wraps to the bottom of the space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | High in the first cycle of a bus read |
| mem_addr | output | 20 | Physical byte address of the current read |
| mem_ready | input | 1 | Memory ready; low stretches the third phase |
| mem_rdata | input | 16 | Word returned by memory, sampled at the end of the third phase |
| deq_valid | output | 1 | Queue holds at least one byte |
| deq_byte | output | 8 | Oldest queued byte |
| deq_ready | input | 1 | Consumer takes the byte on this edge |
| redir_valid | input | 1 | Redirect strobe (jump) |
| redir_seg | input | 16 | New segment value |
| redir_off | input | 16 | New offset value |

## Verification
The assertions check on every cycle that the queue never goes past six bytes, that a redirect leaves it empty and starts no read on the same edge, that `mem_req` lasts one cycle and starts only with room for a word, that the address holds steady through a read, and that a marked read never appends data. Byte order, odd-address handling, the offset and physical-address wrap, the drop of a read cut off by a redirect, and the reset start address can only be shown by the bench. It runs each scenario against a behavioural queue model that is compared every cycle, and it also runs a long stretch with mixed ready stalls, pops and redirects.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

   // bytes delivered by one bus word
   localparam int unsigned IFQ_BUS_BYTES = 2;

   // phases of one bus read
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ADDR = 3'd1,
      PH_CMD  = 3'd2,
      PH_DATA = 3'd3,
      PH_DONE = 3'd4
   } bus_phase_e;

endpackage

// File: rtl/ifq_byte_ring.sv
module ifq_byte_ring #(
   parameter int DEPTH  = 6,
   parameter int BYTE_W = 8,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  flush,
   input  logic                  push_lo,
   input  logic                  push_hi,
   input  logic [2*BYTE_W-1:0]   wdata,
   input  logic                  pop,
   output logic [BYTE_W-1:0]     rdata,
   output logic [CNT_W-1:0]      count
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LANES = int'(ifq_pkg::IFQ_BUS_BYTES);

   logic [BYTE_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              pop_ok;
   logic [LANES-1:0]  lane_en;
   logic [BYTE_W-1:0] lane_byte [LANES];
   logic [PTR_W-1:0]  lane_idx  [LANES];
   int                n_push;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p, input int n);
      int s;
      s = int'(p) + n;
      if (s >= DEPTH) s = s - DEPTH;
      return PTR_W'(s);
   endfunction

   assign pop_ok = pop && (cnt_q != '0);

   // lane 0 carries the first byte to append, lane 1 the second
   assign lane_en[0]   = push_lo | push_hi;
   assign lane_byte[0] = push_lo ? wdata[BYTE_W-1:0] : wdata[2*BYTE_W-1:BYTE_W];
   assign lane_en[1]   = push_lo & push_hi;
   assign lane_byte[1] = wdata[2*BYTE_W-1:BYTE_W];

   always_comb begin
      n_push = 0;
      for (int l = 0; l < LANES; l++) begin
         lane_idx[l] = bump(wr_q, l);
         if (lane_en[l]) n_push = n_push + 1;
      end
   end

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q[s] <= '0;
            end else if (!flush) begin
               if (lane_en[0] && lane_idx[0] == PTR_W'(s))
                  slot_q[s] <= lane_byte[0];
               else if (lane_en[1] && lane_idx[1] == PTR_W'(s))
                  slot_q[s] <= lane_byte[1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop_ok) rd_q <= bump(rd_q, 1);
         wr_q  <= bump(wr_q, n_push);
         cnt_q <= CNT_W'(int'(cnt_q) + n_push - (pop_ok ? 1 : 0));
      end
   end

   assign rdata = slot_q[rd_q];
   assign count = cnt_q;

   initial begin
      assert (DEPTH >= LANES) else $error("ifq_byte_ring: DEPTH below one bus word");
      assert (CNT_W >= $clog2(DEPTH + 1)) else $error("ifq_byte_ring: CNT_W too narrow");
   end

   // R8: occupancy never exceeds capacity
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH);

   // R9: a flush leaves the ring empty
   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0));

   // R7: an ignored pop on empty leaves occupancy unchanged when nothing is appended
   a_r7_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && pop && !lane_en[0] && !flush) |=> (cnt_q == '0));

endmodule

// File: rtl/ifq_fetch_ctrl.sv
module ifq_fetch_ctrl
   import ifq_pkg::*;
#(
   parameter int DEPTH     = 6,
   parameter int MIN_FREE  = 2,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int CNT_W     = $clog2(DEPTH + 1),
   parameter int ADDR_W    = SEG_W + SEG_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic              mem_ready,
   input  logic              redir_valid,
   input  logic [SEG_W-1:0]  redir_seg,
   input  logic [SEG_W-1:0]  redir_off,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              push_lo,
   output logic              push_hi
);
   bus_phase_e        ph_q, ph_d;
   logic [SEG_W-1:0]  seg_q, off_q;
   logic [ADDR_W-1:0] addr_q;
   logic              stale_q;
   logic              room, done, keep, in_flight;

   function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] sg,
                                              input logic [SEG_W-1:0] of);
      return {sg, SEG_SHIFT'(0)} + ADDR_W'(of);
   endfunction

   assign room      = (DEPTH - int'(count)) >= MIN_FREE;
   assign done      = (ph_q == PH_DATA) && mem_ready;
   assign in_flight = (ph_q == PH_ADDR) || (ph_q == PH_CMD) || (ph_q == PH_DATA);
   assign keep      = done && !stale_q && !redir_valid;
   assign push_hi   = keep;
   assign push_lo   = keep && !addr_q[0];

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE, PH_DONE: ph_d = (!redir_valid && room) ? PH_ADDR : PH_IDLE;
         PH_ADDR:          ph_d = PH_CMD;
         PH_CMD:           ph_d = PH_DATA;
         PH_DATA:          ph_d = mem_ready ? PH_DONE : PH_DATA;
         default:          ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         seg_q   <= '1;
         off_q   <= '0;
         addr_q  <= phys('1, '0);
         stale_q <= 1'b0;
      end else begin
         ph_q <= ph_d;
         if (ph_d == PH_ADDR) addr_q <= phys(seg_q, off_q);
         if (redir_valid) begin
            seg_q <= redir_seg;
            off_q <= redir_off;
         end else if (keep) begin
            off_q <= off_q + (addr_q[0] ? SEG_W'(1) : SEG_W'(2));
         end
         if (done)                           stale_q <= 1'b0;
         else if (redir_valid && in_flight)  stale_q <= 1'b1;
      end
   end

   assign mem_req  = (ph_q == PH_ADDR);
   assign mem_addr = addr_q;

   initial begin
      assert (MIN_FREE >= int'(IFQ_BUS_BYTES)) else $error("ifq_fetch_ctrl: MIN_FREE below one word");
      assert (MIN_FREE <= DEPTH) else $error("ifq_fetch_ctrl: MIN_FREE above DEPTH");
   end

   // R3: request strobe lasts a single cycle
   a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R2: address held through the rest of the read
   a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CMD || ph_q == PH_DATA || ph_q == PH_DONE) |-> $stable(mem_addr));

   // R4: a read is only under way with room for a word
   a_r4_start_room: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (int'(count) <= DEPTH - MIN_FREE));

   // R9: no read starts on the redirect edge
   a_r9_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !mem_req);

   // R10: a read cut off by a redirect never appends
   a_r10_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
      stale_q |-> !push_hi);

endmodule

// File: rtl/ifq_prefetch.sv
module ifq_prefetch #(
   parameter int DEPTH     = 6,
   parameter int MIN_FREE  = 2,
   parameter int BYTE_W    = 8,
   parameter int SEG_W     = 16,
   parameter int SEG_SHIFT = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   output logic                        mem_req,
   output logic [SEG_W+SEG_SHIFT-1:0]  mem_addr,
   input  logic                        mem_ready,
   input  logic [2*BYTE_W-1:0]         mem_rdata,
   output logic                        deq_valid,
   output logic [BYTE_W-1:0]           deq_byte,
   input  logic                        deq_ready,
   input  logic                        redir_valid,
   input  logic [SEG_W-1:0]            redir_seg,
   input  logic [SEG_W-1:0]            redir_off
);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int ADDR_W = SEG_W + SEG_SHIFT;

   logic [CNT_W-1:0] count;
   logic             push_lo, push_hi, pop;

   assign deq_valid = (count != '0);
   assign pop       = deq_valid && deq_ready;

   ifq_fetch_ctrl #(
      .DEPTH(DEPTH), .MIN_FREE(MIN_FREE), .SEG_W(SEG_W),
      .SEG_SHIFT(SEG_SHIFT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .count(count), .mem_ready(mem_ready),
      .redir_valid(redir_valid), .redir_seg(redir_seg), .redir_off(redir_off),
      .mem_req(mem_req), .mem_addr(mem_addr), .push_lo(push_lo), .push_hi(push_hi)
   );

   ifq_byte_ring #(
      .DEPTH(DEPTH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .flush(redir_valid), .push_lo(push_lo),
      .push_hi(push_hi), .wdata(mem_rdata), .pop(pop), .rdata(deq_byte),
      .count(count)
   );

   initial begin
      assert (SEG_SHIFT > 0 && SEG_W > 0) else $error("ifq_prefetch: bad address widths");
      assert (BYTE_W > 0) else $error("ifq_prefetch: bad byte width");
   end

endmodule

// File: tb/ifq_prefetch_tb.sv
module ifq_prefetch_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req;
   logic [19:0] mem_addr;
   logic        mem_ready = 1'b1;
   logic [15:0] mem_rdata;
   logic        deq_valid;
   logic [7:0]  deq_byte;
   logic        deq_ready = 1'b0;
   logic        redir_valid = 1'b0;
   logic [15:0] redir_seg = '0;
   logic [15:0] redir_off = '0;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   ifq_prefetch u_dut (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata), .deq_valid(deq_valid),
      .deq_byte(deq_byte), .deq_ready(deq_ready), .redir_valid(redir_valid),
      .redir_seg(redir_seg), .redir_off(redir_off)
   );

   // memory image: byte value is a hash of its address
   function automatic logic [7:0] mbyte(input logic [19:0] a);
      return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
   endfunction

   assign mem_rdata = {mbyte({mem_addr[19:1], 1'b1}), mbyte({mem_addr[19:1], 1'b0})};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // behavioural reference: phase number, segment, offset, byte queue
   int          m_ph;
   logic [15:0] m_cs, m_ip;
   logic [19:0] m_addr;
   bit          m_stale;
   logic [7:0]  m_q[$];

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_ph = 0; m_cs = 16'hFFFF; m_ip = 16'h0000; m_addr = 20'hFFFF0;
         m_stale = 0; m_q.delete();
      end else begin
         automatic bit fin  = (m_ph == 3) && mem_ready;
         automatic int free = 6 - m_q.size();
         automatic bit busy = (m_ph >= 1 && m_ph <= 3);
         if (redir_valid) begin
            m_q.delete();
            m_cs = redir_seg; m_ip = redir_off;
         end else begin
            if (deq_ready && m_q.size() > 0) void'(m_q.pop_front());
            if (fin && !m_stale) begin
               if (!m_addr[0]) begin
                  m_q.push_back(mbyte(m_addr));
                  m_q.push_back(mbyte(m_addr + 20'd1));
                  m_ip = m_ip + 16'd2;
               end else begin
                  m_q.push_back(mbyte(m_addr));
                  m_ip = m_ip + 16'd1;
               end
            end
         end
         if (fin) m_stale = 0;
         else if (redir_valid && busy) m_stale = 1;
         case (m_ph)
            0, 4: if (!redir_valid && free >= 2) begin
                     m_ph = 1;
                     m_addr = {m_cs, 4'h0} + {4'h0, m_ip};
                  end else m_ph = 0;
            1: m_ph = 2;
            2: m_ph = 3;
            3: if (mem_ready) m_ph = 4;
            default: m_ph = 0;
         endcase
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk(mem_req == (m_ph == 1), "R3 mem_req phase", 32'(mem_req), 32'(m_ph == 1));
         chk(mem_addr == m_addr, "R2 mem_addr", 32'(mem_addr), 32'(m_addr));
         chk(deq_valid == (m_q.size() != 0), "R7 deq_valid", 32'(deq_valid), 32'(m_q.size() != 0));
         chk(m_q.size() <= 6, "R8 model occupancy", 32'(m_q.size()), 32'd6);
         if (deq_valid && m_q.size() != 0)
            chk(deq_byte == m_q[0], "R5 deq_byte order", 32'(deq_byte), 32'(m_q[0]));
      end
   end

   task automatic redirect(input logic [15:0] sg, input logic [15:0] of);
      redir_valid = 1'b1; redir_seg = sg; redir_off = of;
      @(negedge clk);
      redir_valid = 1'b0;
   endtask

   task automatic wait_req();
      for (int i = 0; i < 300 && !mem_req; i++) @(negedge clk);
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 300 && !deq_valid; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
            finish_run();
         end
      end
   end

   initial begin
      int reqs, gap, last, pops;
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      deq_ready = 1'b1;
      @(negedge clk);
      chk(deq_valid == 1'b0, "R1 empty during reset", 32'(deq_valid), 32'd0);
      deq_ready = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_req == 1'b1, "R1 first request", 32'(mem_req), 32'd1);
      chk(mem_addr == 20'hFFFF0, "R1 first address", 32'(mem_addr), 32'hFFFF0);
      chk(deq_valid == 1'b0, "R1 empty after reset", 32'(deq_valid), 32'd0);

      // R4 / R3: no pops, ready high -> three reads, four cycles apart
      reqs = 1; gap = 0; last = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (mem_req) begin
            reqs++;
            if (gap == 0) gap = i - last;
            last = i;
         end
      end
      chk(reqs == 3, "R4 reads with full queue", 32'(reqs), 32'd3);
      chk(gap == 4, "R3 read spacing", 32'(gap), 32'd4);
      chk(deq_byte == mbyte(20'hFFFF0), "R5 low byte first", 32'(deq_byte), 32'(mbyte(20'hFFFF0)));

      // R8: concurrent drain and fetch
      deq_ready = 1'b1; pops = 0;
      for (int i = 0; i < 100; i++) begin
         if (deq_valid) pops++;
         @(negedge clk);
      end
      chk(pops >= 40, "R8 pops while fetching", 32'(pops), 32'd40);

      // R9: redirect empties queue, no start on that edge
      deq_ready = 1'b0;
      repeat (10) @(negedge clk);
      redirect(16'h1234, 16'h0011);
      chk(deq_valid == 1'b0, "R9 flushed", 32'(deq_valid), 32'd0);
      chk(mem_req == 1'b0, "R9 no start on redirect", 32'(mem_req), 32'd0);

      // R6: odd start keeps only the byte at the odd address
      wait_valid();
      chk(deq_byte == mbyte(20'h12351), "R6 odd single byte", 32'(deq_byte), 32'(mbyte(20'h12351)));

      // R10: redirect while a read stalls on the bus
      redirect(16'h2000, 16'h0000);
      mem_ready = 1'b0;
      wait_req();
      @(negedge clk); @(negedge clk);
      redirect(16'h0800, 16'h0100);
      mem_ready = 1'b1;
      wait_valid();
      chk(deq_byte == mbyte(20'h08100), "R10 stale read dropped", 32'(deq_byte), 32'(mbyte(20'h08100)));

      // R11: physical wrap above FFFFFh
      redirect(16'hFFFF, 16'h0020);
      wait_req();
      chk(mem_addr == 20'h00010, "R11 physical wrap", 32'(mem_addr), 32'h00010);

      // R11: offset wrap at FFFFh
      redirect(16'h0000, 16'hFFFF);
      wait_req();
      chk(mem_addr == 20'h0FFFF, "R11 odd top of segment", 32'(mem_addr), 32'h0FFFF);
      @(negedge clk);
      wait_req();
      chk(mem_addr == 20'h00000, "R11 offset wraps to zero", 32'(mem_addr), 32'h00000);

      // R7: pop attempts on empty after redirect with memory stalled
      mem_ready = 1'b0; deq_ready = 1'b1;
      redirect(16'h0100, 16'h0000);
      repeat (6) @(negedge clk);
      chk(deq_valid == 1'b0, "R7 empty pop inert", 32'(deq_valid), 32'd0);
      mem_ready = 1'b1;

      // mixed traffic: stalls, pops, redirects
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         mem_ready = (lfsr[1:0] != 2'b00);
         deq_ready = lfsr[4];
         if (lfsr[10:5] == 6'h2A) begin
            redir_valid = 1'b1; redir_seg = lfsr[31:16]; redir_off = lfsr[27:12];
         end else redir_valid = 1'b0;
         @(negedge clk);
      end
      redir_valid = 1'b0;
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule